// File: doc/BRIEF.md
# Scan vector sequencer controller

This block is the control state machine of a boundary-scan test master that decides which stored scan vector the shift engine runs next. In sequencer mode it reads a program from a small synchronous memory: a pass count first, then pairs of vector number and repeat count. It starts each selected vector on the shift engine as many times as asked and replays the whole list once per pass. In single-vector mode it starts the lowest enabled vector once and then goes back to idle.

The shift engine is reached through a start pulse with a vector index and a completion pulse. The mode controls are plain register inputs. Status outputs show which mode is active. There is a one-cycle pulse that clears the compare-result flag held elsewhere, and a one-cycle pulse when the controller finishes.

Top module: `scan_seq_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, run_start_o, mem_req_o, cmp_clr_o, using_seq_o and using_vec_o are all low.
- R2: A start_i seen in idle with seq_en_i high raises cmp_clr_o for exactly one cycle and holds using_seq_o high for as long as busy_o is high.
- R3: The program memory returns the word at mem_addr_o in the cycle after mem_req_o. Address 0 holds the pass count. Every pass reads from address 1 upward, in pairs: the vector number at the lower address and its repeat count at the next.
- R4: A pass count of zero ends the run without any run_start_o pulse and clears using_seq_o.
- R5: A vector number of zero, or one above NVEC, ends the current pass. The pass count is decremented and the next pass restarts at address 1.
- R6: A legal vector number v with repeat count n gives n run_start_o pulses with run_sel_o = v, each one issued after the previous run_done_i. When n is zero the pair is skipped.
- R7: The full list is replayed once for each unit of the pass count.
- R8: With seq_en_i low and vec_en_i non-zero, a start runs vector i+1 once, where i is the lowest set bit of vec_en_i. using_vec_o holds the one-hot of bit i while busy_o is high.
- R9: With seq_en_i low and vec_en_i zero, a start returns to idle without any run_start_o pulse.
- R10: Every return to idle is marked by done_o high for one cycle with busy_o low. The status bits are cleared in that same cycle.
- R11: start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled in idle |
| seq_en_i | input | 1 | Select sequencer mode |
| vec_en_i | input | NVEC | Per-vector enables for single-vector mode |
| mem_req_o | output | 1 | Program memory read strobe |
| mem_addr_o | output | AW | Program memory address |
| mem_rdata_i | input | DW | Read data, valid the cycle after the strobe |
| run_start_o | output | 1 | One-cycle start to the shift engine |
| run_sel_o | output | VW | Vector number to run (1..NVEC) |
| run_done_i | input | 1 | One-cycle completion from the shift engine |
| busy_o | output | 1 | Controller active |
| using_seq_o | output | 1 | Sequencer mode in progress |
| using_vec_o | output | NVEC | One-hot of the single vector in progress |
| cmp_clr_o | output | 1 | Clears the compare-result status |
| done_o | output | 1 | Return-to-idle pulse |

## Verification
The assertions assume that run_done_i only arrives while a started vector is outstanding, and at most once for each run_start_o. They also assume that the memory answers every strobe in the next cycle. The bench's shift-engine model answers each start exactly once, after a fixed delay. Its memory model registers the addressed word on every strobe. Mode inputs stay constant from the start pulse until done_o, except for a deliberate second start_i that is sent mid-run to check that it is ignored.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SRD, S_SWT, S_CHK, S_NRD, S_NWT, S_CRD, S_CWT,
    S_VCHK, S_RUN, S_WAIT, S_ONE_RUN, S_ONE_WAIT, S_END
  } seq_st_e;
endpackage

// File: rtl/seq_dn_counter.sv
module seq_dn_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R6/R7: a repeat count never wraps below zero
  p_dec_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> !zero_o);
  p_load_dec_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && dec_i));
endmodule

// File: rtl/seq_fetch_ptr.sv
module seq_fetch_ptr #(
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,   // to pass-count word
  input  logic          pass_i,  // to first pair
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_o <= '0;
    else if (clr_i)   addr_o <= '0;
    else if (pass_i)  addr_o <= AW'(1);
    else if (inc_i)   addr_o <= addr_o + 1'b1;
  end

  // R3: each pass starts over at the first pair
  p_pass_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i && !clr_i |=> addr_o == AW'(1));
endmodule

// File: rtl/vec_prio_pick.sv
module vec_prio_pick #(
  parameter int NVEC = 4,
  localparam int VW = $clog2(NVEC + 1)
) (
  input  logic [NVEC-1:0] en_i,
  output logic            hit_o,
  output logic [NVEC-1:0] oh_o,
  output logic [VW-1:0]   num_o
);
  logic [NVEC:0] below;
  assign below[0] = 1'b0;

  for (genvar i = 0; i < NVEC; i++) begin : g_pick
    assign below[i+1] = below[i] | en_i[i];
    assign oh_o[i]    = en_i[i] & ~below[i];
  end

  assign hit_o = below[NVEC];

  always_comb begin
    num_o = '0;
    for (int i = 0; i < NVEC; i++)
      if (oh_o[i]) num_o = VW'(i + 1);
  end

  // R8: at most one vector picked
  always_comb a_pick_onehot_r8: assert ($onehot0(oh_o));
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int NVEC = 4,
  parameter int AW   = 6,
  parameter int DW   = 8,
  localparam int VW  = $clog2(NVEC + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            seq_en_i,
  input  logic [NVEC-1:0] vec_en_i,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_addr_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            run_start_o,
  output logic [VW-1:0]   run_sel_o,
  input  logic            run_done_i,
  output logic            busy_o,
  output logic            using_seq_o,
  output logic [NVEC-1:0] using_vec_o,
  output logic            cmp_clr_o,
  output logic            done_o
);
  seq_st_e st_q, st_d;

  logic [DW-1:0]   vnum_q;
  logic [VW-1:0]   one_sel_q;
  logic            cmp_clr_q;
  logic            pick_hit;
  logic [NVEC-1:0] pick_oh;
  logic [VW-1:0]   pick_num;
  logic            seq_zero, vcnt_zero, legal;
  logic            seq_load, seq_dec, vcnt_load, vcnt_dec;
  logic            ptr_clr, ptr_pass, ptr_inc;
  logic            go_seq, go_one;

  assign go_seq = (st_q == S_IDLE) && start_i && seq_en_i;
  assign go_one = (st_q == S_IDLE) && start_i && !seq_en_i && pick_hit;
  assign legal  = (vnum_q != '0) && (vnum_q <= DW'(NVEC));

  vec_prio_pick #(.NVEC(NVEC)) i_pick (
    .en_i(vec_en_i), .hit_o(pick_hit), .oh_o(pick_oh), .num_o(pick_num)
  );

  seq_dn_counter #(.W(DW)) i_seq_cnt (
    .clk_i, .rst_ni, .load_i(seq_load), .val_i(mem_rdata_i),
    .dec_i(seq_dec), .zero_o(seq_zero)
  );

  seq_dn_counter #(.W(DW)) i_vec_cnt (
    .clk_i, .rst_ni, .load_i(vcnt_load), .val_i(mem_rdata_i),
    .dec_i(vcnt_dec), .zero_o(vcnt_zero)
  );

  seq_fetch_ptr #(.AW(AW)) i_ptr (
    .clk_i, .rst_ni, .clr_i(ptr_clr), .pass_i(ptr_pass), .inc_i(ptr_inc),
    .addr_o(mem_addr_o)
  );

  always_comb begin
    st_d      = st_q;
    seq_load  = 1'b0;
    seq_dec   = 1'b0;
    vcnt_load = 1'b0;
    vcnt_dec  = 1'b0;
    ptr_clr   = go_seq;
    ptr_pass  = 1'b0;
    ptr_inc   = 1'b0;
    unique case (st_q)
      S_IDLE:     if (start_i) st_d = seq_en_i ? S_SRD : (pick_hit ? S_ONE_RUN : S_END);
      S_SRD:      st_d = S_SWT;
      S_SWT:      begin seq_load = 1'b1; st_d = S_CHK; end
      S_CHK:      begin ptr_pass = 1'b1; st_d = seq_zero ? S_END : S_NRD; end
      S_NRD:      st_d = S_NWT;
      S_NWT:      begin ptr_inc = 1'b1; st_d = S_CRD; end
      S_CRD:      st_d = S_CWT;
      S_CWT:      begin ptr_inc = 1'b1; vcnt_load = 1'b1; st_d = S_VCHK; end
      S_VCHK:
        if (!legal)         begin seq_dec = 1'b1; st_d = S_CHK; end
        else if (vcnt_zero) st_d = S_NRD;
        else                st_d = S_RUN;
      S_RUN:      st_d = S_WAIT;
      S_WAIT:     if (run_done_i) begin vcnt_dec = 1'b1; st_d = S_VCHK; end
      S_ONE_RUN:  st_d = S_ONE_WAIT;
      S_ONE_WAIT: if (run_done_i) st_d = S_END;
      S_END:      st_d = S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      vnum_q      <= '0;
      one_sel_q   <= '0;
      cmp_clr_q   <= 1'b0;
      using_seq_o <= 1'b0;
      using_vec_o <= '0;
    end else begin
      st_q      <= st_d;
      cmp_clr_q <= go_seq;
      if (st_q == S_NWT) vnum_q <= mem_rdata_i;
      if (go_seq) using_seq_o <= 1'b1;
      if (go_one) begin
        using_vec_o <= pick_oh;
        one_sel_q   <= pick_num;
      end
      if (st_d == S_END) begin
        using_seq_o <= 1'b0;
        using_vec_o <= '0;
      end
    end
  end

  assign mem_req_o   = (st_q == S_SRD) || (st_q == S_NRD) || (st_q == S_CRD);
  assign run_start_o = (st_q == S_RUN) || (st_q == S_ONE_RUN);
  assign run_sel_o   = (st_q == S_RUN) ? vnum_q[VW-1:0] :
                       (st_q == S_ONE_RUN) ? one_sel_q : '0;
  assign busy_o      = (st_q != S_IDLE) && (st_q != S_END);
  assign done_o      = (st_q == S_END);
  assign cmp_clr_o   = cmp_clr_q;

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !using_seq_o && using_vec_o == '0);
  p_cmp_clr_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_clr_o |-> using_seq_o && busy_o);
  p_mode_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(using_seq_o && using_vec_o != '0));
  p_vec_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(using_vec_o));
  p_run_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_o |-> run_sel_o != '0 && run_sel_o <= VW'(NVEC));
  p_run_spaced_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_start_o |=> !run_start_o);
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !run_start_o && !mem_req_o);
endmodule

// File: tb/test_scan_seq_ctrl.sv
module test_scan_seq_ctrl;
  localparam int NVEC = 4;
  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int VW   = $clog2(NVEC + 1);
  localparam int LAT  = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            seq_en = 1'b0;
  logic [NVEC-1:0] vec_en = '0;
  logic            mem_req;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_rdata = '0;
  logic            run_start;
  logic [VW-1:0]   run_sel;
  logic            run_done = 1'b0;
  logic            busy, using_seq, cmp_clr, done;
  logic [NVEC-1:0] using_vec;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [64];
  int got[$];
  int done_seen = 0, clr_seen = 0;
  bit exp_seq = 1'b0;
  logic [NVEC-1:0] exp_oh = '0;
  int dcnt = 0;

  always #2 clk = ~clk;

  scan_seq_ctrl #(.NVEC(NVEC), .AW(AW), .DW(DW)) i_scan_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .seq_en_i(seq_en),
    .vec_en_i(vec_en), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rdata_i(mem_rdata), .run_start_o(run_start), .run_sel_o(run_sel),
    .run_done_i(run_done), .busy_o(busy), .using_seq_o(using_seq),
    .using_vec_o(using_vec), .cmp_clr_o(cmp_clr), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // memory and shift-engine models plus per-cycle reference compare
  always @(negedge clk) begin
    if (mem_req) mem_rdata = mem[mem_addr];
    if (run_done) run_done = 1'b0;
    if (run_start) dcnt = LAT;
    else if (dcnt != 0) begin
      dcnt--;
      if (dcnt == 0) run_done = 1'b1;
    end
    if (rst_n) begin
      if (run_start) begin
        got.push_back(int'(run_sel));
        chk(busy, "R6 start while busy", busy, 1);
      end
      chk(using_seq == (busy && exp_seq), "R2 using_seq", using_seq, busy && exp_seq);
      chk(using_vec == ((busy && !exp_seq) ? exp_oh : '0), "R8 using_vec",
          using_vec, (busy && !exp_seq) ? exp_oh : 0);
      if (done) begin
        done_seen++;
        chk(!busy, "R10 done with busy low", busy, 0);
      end
      if (cmp_clr) clr_seen++;
    end
  end

  function automatic void build_expect(output int q[$]);
    int passes, p, n, c;
    q = {};
    passes = mem[0];
    while (passes > 0) begin
      p = 1;
      forever begin
        n = mem[p]; c = mem[p+1]; p += 2;
        if (n < 1 || n > NVEC) break;
        repeat (c) q.push_back(n);
      end
      passes--;
    end
  endfunction

  task automatic run_case(input string req, input bit s_en, input logic [NVEC-1:0] v_en,
                          input bit poke);
    int exp_q[$];
    int w;
    if (s_en) build_expect(exp_q);
    else begin
      exp_q = {};
      exp_oh = '0;
      for (int i = NVEC - 1; i >= 0; i--)
        if (v_en[i]) begin exp_oh = '0; exp_oh[i] = 1'b1; end
      for (int i = 0; i < NVEC; i++)
        if (exp_oh[i]) exp_q.push_back(i + 1);
    end
    got = {};
    done_seen = 0;
    clr_seen = 0;
    @(negedge clk);
    seq_en = s_en; vec_en = v_en; exp_seq = s_en;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      seq_en = ~s_en; vec_en = ~v_en; start = 1'b1; // R11: must be ignored
      @(negedge clk);
      start = 1'b0; seq_en = s_en; vec_en = v_en;
    end
    w = 0;
    while (done_seen == 0 && w < 3000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk(done_seen == 1, {req, " R10 one done pulse"}, done_seen, 1);
    chk(clr_seen == (s_en ? 1 : 0), {req, " R2 cmp_clr pulses"}, clr_seen, s_en ? 1 : 0);
    chk(got.size() == exp_q.size(), {req, " vector count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      chk(got[i] == exp_q[i], {req, " vector order"}, got[i], exp_q[i]);
    chk(!busy && !using_seq && using_vec == '0, {req, " idle after"}, busy, 0);
  endtask

  task automatic clear_mem;
    for (int i = 0; i < 64; i++) mem[i] = '0;
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !run_start && !mem_req && !cmp_clr && !using_seq &&
        using_vec == '0, "R1 reset outputs", busy, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    mem[0] = 2; mem[1] = 1; mem[2] = 2; mem[3] = 3; mem[4] = 1; mem[5] = 0;
    run_case("R3 R6 R7 two passes", 1'b1, '0, 1'b0);
    run_case("R11 start while busy", 1'b1, 4'b0101, 1'b1);

    clear_mem();
    run_case("R4 zero pass count", 1'b1, '0, 1'b0);

    clear_mem();
    mem[0] = 1; mem[1] = 2; mem[2] = 1; mem[3] = 7; mem[4] = 3; mem[5] = 4; mem[6] = 1;
    run_case("R5 illegal number", 1'b1, '0, 1'b0);

    clear_mem();
    mem[0] = 3; mem[1] = 4; mem[2] = 0; mem[3] = 2; mem[4] = 2; mem[5] = 5;
    run_case("R6 R7 zero repeat skip", 1'b1, '0, 1'b0);

    run_case("R8 lowest enable", 1'b0, 4'b0110, 1'b0);
    run_case("R8 top vector", 1'b0, 4'b1000, 1'b0);
    run_case("R9 nothing enabled", 1'b0, 4'b0000, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule